// File: doc/BRIEF.md
# Bus Cycle Event Capture for a CPU Bus Monitor

This block sits on a bus-monitor board and watches the control lines of an 8-bit CPU with a 16-bit address bus. It sorts every sampled bus state into one of five cycle classes: memory read, memory write, I/O read, I/O write and opcode fetch. A class is captured only while its own enable input is set, so the display shows only the chosen kinds of activity, such as writes to memory.

When an enabled class first appears, the block produces a one-cycle capture strobe. On the same clock edge it latches the address and data into eight hex digit nibbles. It also produces a load pulse on that edge and latches an active-high snapshot of the control lines. Some of the decimal points on the display show that snapshot. Everything holds until the next qualifying bus cycle.

Top module: `bus_event_capture`

## Requirements
- R1: Each class has an enable bit whose index is its class code (0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 opcode fetch). A class is captured only while its bit is set.
- R2: Decoding uses active-low inputs:
  - Opcode fetch is M1, memory request and read all active. It takes priority over memory read.
  - Memory read is memory request and read with M1 inactive.
  - Memory write is memory request and write.
  - I/O read is I/O request and read with M1 inactive.
  - I/O write is I/O request and write.
  - No class results from: memory request alone (refresh), both requests active together, both read and write active together, or M1 with an I/O request (interrupt acknowledge).
- R3: `strobe_o` is high for exactly one cycle, two rising edges after a qualifying state is presented on the inputs. It fires once per contiguous qualifying period and fires again only after qualification has dropped for at least one sampled cycle.
- R4: `load_o` pulses in the same cycle as `strobe_o`. On that edge `ctrl_o` latches the active-high control lines with bit 0 memory request, bit 1 I/O request, bit 2 read, bit 3 write and bit 4 M1.
- R5: Digit k occupies `digits_o[4k+3:4k]`. Digits 0 to 3 hold address nibbles A0-A3, A4-A7, A8-A11 and A12-A15. Digits 4 and 5 hold data bits D0-D3 and D4-D7. Digit 6 holds the class code. Digit 7 holds `ctrl_o[3:0]`.
- R6: `dp_o[k]` equals `ctrl_o[k]` for k from 0 to 4, and `dp_o[7:5]` is zero.
- R7: Between strobes, `digits_o`, `ctrl_o` and `dp_o` hold their last captured values whatever the bus does.
- R8: After reset, all outputs are zero.
- R9: With every enable bit clear, neither `strobe_o` nor `load_o` pulses for any bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read, active low |
| wr_n | input | 1 | Write, active low |
| m1_n | input | 1 | Opcode fetch marker, active low |
| addr_i | input | 16 | CPU address bus |
| data_i | input | 8 | CPU data bus |
| class_en_i | input | 5 | Per-class capture enables, indexed by class code |
| digits_o | output | 32 | Latched hex nibbles for eight digits |
| dp_o | output | 8 | Decimal points showing latched control lines |
| ctrl_o | output | 5 | Latched active-high control snapshot |
| strobe_o | output | 1 | One-cycle pulse when address and data are latched |
| load_o | output | 1 | One-cycle pulse when the control snapshot is latched |

## Verification
The bench builds the block with its default widths: a 16-bit address, an 8-bit data bus and five classes. This keeps the enable space small enough to sweep all 32 masks. Each mask is run against every valid class and against three illegal line combinations. This exercises enable gating, decode priority and the no-enable case together. Address and data values are derived from the loop indices, so every nibble position carries a distinct value that the bench recomputes arithmetically. Holding a qualifying state for several cycles, then idling, confirms both the single pulse and the retention of the latched values.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int NUM_CLASSES = 5;
  localparam int CTRL_W      = 5;

  typedef enum logic [2:0] {
    CLS_MEMRD = 3'd0,
    CLS_MEMWR = 3'd1,
    CLS_IORD  = 3'd2,
    CLS_IOWR  = 3'd3,
    CLS_FETCH = 3'd4,
    CLS_NONE  = 3'd7
  } bus_class_e;

  // ctrl bits, active high: 0 mreq, 1 iorq, 2 rd, 3 wr, 4 m1
  function automatic bus_class_e classify(input logic [CTRL_W-1:0] c);
    logic mreq, iorq, rd, wr, m1;
    mreq = c[0]; iorq = c[1]; rd = c[2]; wr = c[3]; m1 = c[4];
    if ((mreq && iorq) || (rd && wr))      return CLS_NONE;
    else if (mreq && rd && m1)             return CLS_FETCH;
    else if (mreq && rd)                   return CLS_MEMRD;
    else if (mreq && wr)                   return CLS_MEMWR;
    else if (iorq && rd && !m1)            return CLS_IORD;
    else if (iorq && wr)                   return CLS_IOWR;
    else                                   return CLS_NONE;
  endfunction

  function automatic logic [3:0] nibble_of(input logic [31:0] v, input int k);
    return 4'((v >> (4 * k)) & 32'hF);
  endfunction
endpackage

// File: rtl/bec_sampler.sv
module bec_sampler #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int EN_W   = 5,
  parameter int CTRL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_act_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [EN_W-1:0]   en_i,
  output logic [CTRL_W-1:0] ctrl_s_o,
  output logic [ADDR_W-1:0] addr_s_o,
  output logic [DATA_W-1:0] data_s_o,
  output logic [EN_W-1:0]   en_s_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_s_o <= '0;
      addr_s_o <= '0;
      data_s_o <= '0;
      en_s_o   <= '0;
    end else begin
      ctrl_s_o <= ctrl_act_i;
      addr_s_o <= addr_i;
      data_s_o <= data_i;
      en_s_o   <= en_i;
    end
  end
endmodule

// File: rtl/bec_qualifier.sv
module bec_qualifier
  import bec_pkg::*;
#(
  parameter int EN_W   = 5,
  parameter int CTRL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_s_i,
  input  logic [EN_W-1:0]   en_s_i,
  output logic              capture_o,
  output logic [2:0]        class_o,
  output logic              strobe_o,
  output logic              load_o
);
  bus_class_e cls;
  logic       qual;
  logic       qual_q;

  always_comb begin
    cls  = classify(ctrl_s_i);
    qual = (cls != CLS_NONE) && en_s_i[cls];
  end

  assign capture_o = qual && !qual_q;
  assign class_o   = cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q   <= 1'b0;
      strobe_o <= 1'b0;
      load_o   <= 1'b0;
    end else begin
      qual_q   <= qual;
      strobe_o <= capture_o;
      load_o   <= capture_o;
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o); // R3

  AST_STROBE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> ($past(cls) != CLS_NONE) && $past(en_s_i[cls])); // R1

  always @(posedge clk) if (rst_n) begin
    AST_LOAD_WITH_STROBE: assert (load_o == strobe_o); // R4
  end
endmodule

// File: rtl/bec_display_latch.sv
module bec_display_latch
  import bec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTRL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [2:0]        class_i,
  input  logic [CTRL_W-1:0] ctrl_s_i,
  input  logic [ADDR_W-1:0] addr_s_i,
  input  logic [DATA_W-1:0] data_s_i,
  output logic [((ADDR_W/4)+(DATA_W/4)+2)*4-1:0] digits_o,
  output logic [((ADDR_W/4)+(DATA_W/4)+2)-1:0]   dp_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam int ADDR_DIGITS = ADDR_W / 4;
  localparam int DATA_DIGITS = DATA_W / 4;
  localparam int NUM_DIGITS  = ADDR_DIGITS + DATA_DIGITS + 2;
  localparam int CLASS_DIGIT = ADDR_DIGITS + DATA_DIGITS;
  localparam int FLAG_DIGIT  = CLASS_DIGIT + 1;

  logic [3:0] next_nib [NUM_DIGITS];

  genvar g;
  generate
    for (g = 0; g < ADDR_DIGITS; g++) begin : g_addr
      assign next_nib[g] = nibble_of(32'(addr_s_i), g);
    end
    for (g = 0; g < DATA_DIGITS; g++) begin : g_data
      assign next_nib[ADDR_DIGITS + g] = nibble_of(32'(data_s_i), g);
    end
  endgenerate

  assign next_nib[CLASS_DIGIT] = {1'b0, class_i};
  assign next_nib[FLAG_DIGIT]  = ctrl_s_i[3:0];

  generate
    for (g = 0; g < NUM_DIGITS; g++) begin : g_digit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         digits_o[4*g +: 4] <= 4'h0;
        else if (capture_i) digits_o[4*g +: 4] <= next_nib[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_o <= '0;
    else if (capture_i) ctrl_o <= ctrl_s_i;
  end

  generate
    for (g = 0; g < NUM_DIGITS; g++) begin : g_dp
      if (g < CTRL_W) begin : g_on
        assign dp_o[g] = ctrl_o[g];
      end else begin : g_off
        assign dp_o[g] = 1'b0;
      end
    end
  endgenerate

  AST_DIGITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture_i) |-> $stable(digits_o) && $stable(ctrl_o)); // R7

  AST_ADDR_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(capture_i) |-> digits_o[3:0] == $past(addr_s_i[3:0])); // R5
endmodule

// File: rtl/bus_event_capture.sv
module bus_event_capture
  import bec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mreq_n,
  input  logic                   iorq_n,
  input  logic                   rd_n,
  input  logic                   wr_n,
  input  logic                   m1_n,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      data_i,
  input  logic [NUM_CLASSES-1:0] class_en_i,
  output logic [((ADDR_W/4)+(DATA_W/4)+2)*4-1:0] digits_o,
  output logic [((ADDR_W/4)+(DATA_W/4)+2)-1:0]   dp_o,
  output logic [CTRL_W-1:0]      ctrl_o,
  output logic                   strobe_o,
  output logic                   load_o
);
  logic [CTRL_W-1:0]      ctrl_act;
  logic [CTRL_W-1:0]      ctrl_s;
  logic [ADDR_W-1:0]      addr_s;
  logic [DATA_W-1:0]      data_s;
  logic [NUM_CLASSES-1:0] en_s;
  logic                   capture;
  logic [2:0]             cls;

  assign ctrl_act = {~m1_n, ~wr_n, ~rd_n, ~iorq_n, ~mreq_n};

  bec_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_W(NUM_CLASSES), .CTRL_W(CTRL_W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .ctrl_act_i(ctrl_act), .addr_i(addr_i), .data_i(data_i),
    .en_i(class_en_i), .ctrl_s_o(ctrl_s), .addr_s_o(addr_s), .data_s_o(data_s), .en_s_o(en_s)
  );

  bec_qualifier #(.EN_W(NUM_CLASSES), .CTRL_W(CTRL_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .ctrl_s_i(ctrl_s), .en_s_i(en_s),
    .capture_o(capture), .class_o(cls), .strobe_o(strobe_o), .load_o(load_o)
  );

  bec_display_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .capture_i(capture), .class_i(cls), .ctrl_s_i(ctrl_s),
    .addr_s_i(addr_s), .data_s_i(data_s), .digits_o(digits_o), .dp_o(dp_o), .ctrl_o(ctrl_o)
  );

  AST_QUIET_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_s) == '0) |-> !strobe_o && !load_o); // R9

  AST_SNAPSHOT_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> ctrl_o == $past(ctrl_s)); // R4
endmodule

// File: tb/tb_bus_event_capture.sv
module tb_bus_event_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [4:0]  class_en_i = '0;
  logic [31:0] digits_o;
  logic [7:0]  dp_o;
  logic [4:0]  ctrl_o;
  logic        strobe_o, load_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] exp_digits = '0;
  logic [4:0]  exp_ctrl = '0;

  always #2.5 clk = ~clk;

  bus_event_capture dut (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .m1_n(m1_n), .addr_i(addr_i), .data_i(data_i), .class_en_i(class_en_i),
    .digits_o(digits_o), .dp_o(dp_o), .ctrl_o(ctrl_o), .strobe_o(strobe_o), .load_o(load_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pattern p: 0..4 class codes, 5 refresh, 6 both requests, 7 interrupt acknowledge
  function automatic logic [4:0] pat_ctrl(input int p);
    case (p)
      0: return 5'b00101;  // mreq rd
      1: return 5'b01001;  // mreq wr
      2: return 5'b00110;  // iorq rd
      3: return 5'b01010;  // iorq wr
      4: return 5'b10101;  // m1 mreq rd
      5: return 5'b00001;  // mreq alone
      6: return 5'b00111;  // mreq iorq rd
      default: return 5'b10010;  // m1 iorq
    endcase
  endfunction

  task automatic drive(input logic [4:0] c);
    mreq_n = ~c[0]; iorq_n = ~c[1]; rd_n = ~c[2]; wr_n = ~c[3]; m1_n = ~c[4];
  endtask

  task automatic idle();
    drive(5'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 digits", digits_o, 0);
    chk("R8 ctrl", {27'b0, ctrl_o}, 0);
    chk("R8 dp", {24'b0, dp_o}, 0);
    chk("R8 strobe", {30'b0, strobe_o, load_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 32; m++) begin
      for (int p = 0; p < 8; p++) begin
        logic [4:0] c;
        logic       hit;
        c = pat_ctrl(p);
        hit = (p < 5) && m[p];
        class_en_i = 5'(m);
        addr_i = 16'((m * 8 + p) * 16'h1357 + 16'h0A1B);
        data_i = 8'((m * 8 + p) * 8'h2D + 8'h5C);
        drive(c);
        @(negedge clk);
        chk("R3 no early strobe", {31'b0, strobe_o}, 0);
        @(negedge clk);
        if (p >= 5) chk("R2 illegal pattern ignored", {31'b0, strobe_o}, 0);
        else if (m == 0) chk("R9 no enables no pulse", {30'b0, strobe_o, load_o}, 0);
        else chk("R1 enable gating", {31'b0, strobe_o}, {31'b0, hit});
        chk("R4 load with strobe", {31'b0, load_o}, {31'b0, strobe_o});
        if (hit) begin
          exp_ctrl = c;
          exp_digits = {c[3:0], 1'b0, 3'(p), data_i[7:4], data_i[3:0],
                        addr_i[15:12], addr_i[11:8], addr_i[7:4], addr_i[3:0]};
        end
        chk("R5 digits", digits_o, exp_digits);
        chk("R4 ctrl snapshot", {27'b0, ctrl_o}, {27'b0, exp_ctrl});
        chk("R6 decimal points", {24'b0, dp_o}, {24'b0, 3'b000, exp_ctrl});
        @(negedge clk);
        chk("R3 single pulse", {30'b0, strobe_o, load_o}, 0);
        addr_i = ~addr_i; data_i = ~data_i;
        @(negedge clk);
        chk("R3 once per cycle", {31'b0, strobe_o}, 0);
        idle();
        repeat (2) @(negedge clk);
        chk("R7 hold digits", digits_o, exp_digits);
        chk("R7 hold ctrl", {27'b0, ctrl_o}, {27'b0, exp_ctrl});
      end
    end
    // re-trigger after a one-cycle gap: memory write, enabled
    class_en_i = 5'b00010;
    drive(pat_ctrl(1));
    repeat (3) @(negedge clk);
    idle();
    @(negedge clk);
    drive(pat_ctrl(1));
    repeat (2) @(negedge clk);
    chk("R3 retrigger after gap", {31'b0, strobe_o}, 1);
    idle();
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule